// File: doc/BRIEF.md
# Subranging Converter Conversion and Calibration Sequencer

This block is the clock-synchronous control core for a three-pass subranging analog-to-digital converter. On every rising clock edge it samples a start request. When it accepts one, it raises a hold command for the track/hold. It then steps through three flash-strobe passes and loads the reference DAC between them. When the hold command drops, it announces a finished result. The analog parts and the correction arithmetic are not in this block. The block only produces their strobe and load timing.

The block also arbitrates an active-low calibration request against conversions. A request that arrives during a conversion is held pending until that conversion ends. A request that arrives while the block is idle starts calibration on the same edge at which it is sampled. Calibration runs for a parameterised number of clocks and drives a busy status for that whole time. While the request stays low, calibration repeats with no gap. Start requests are ignored for a fixed recovery window after a conversion and after a calibration. A calibration request always wins over a start request.

Top module: `subrange_seq`

## Requirements
- R1: When the block is idle and start_i is sampled high at a rising edge with no calibration request present, hold_o is high in the cycle that follows that edge.
- R2: hold_o stays high for exactly HOLD_CLKS (default 13) consecutive cycles per conversion.
- R3: While start_i is held high continuously, hold_o rises once every HOLD_CLKS + CONV_GAP (default 20) cycles.
- R4: After the edge at which hold_o falls, start_i is ignored at the next CONV_GAP-1 (default 6) edges. It is sampled at the CONV_GAP-th edge and at every edge after that until a high is seen.
- R5: Counting the cycle after the accepting edge as hold cycle 0, the default timing is as follows. strobe_o[0] is high in hold cycle 1 and dac_load_o[0] in hold cycle 2. strobe_o[1] is high in hold cycle 4 and dac_load_o[1] in hold cycle 5. strobe_o[2] is high in hold cycle 7. Bit i of strobe_o is pass i+1, and at most one strobe or load bit is high in any cycle.
- R6: A low on cal_n_i sampled during a conversion is latched as pending. cal_busy_o then rises after the first edge that follows the edge at which hold_o falls.
- R7: When the block is not converting and not calibrating, a low on cal_n_i sampled at an edge makes cal_busy_o high after that edge. This holds even when start_i is high at the same edge, and no conversion starts in that case.
- R8: cal_busy_o stays high for exactly CAL_CLKS cycles. A cal_n_i low pulse that is released before the final edge of a calibration leaves no further calibration behind.
- R9: If cal_n_i is still low at the final edge of a calibration, the next calibration follows with no gap, so cal_busy_o stays high for a whole multiple of CAL_CLKS cycles.
- R10: After the edge at which cal_busy_o falls, start_i is ignored at the next CAL_GAP-1 (default 16) edges. It is sampled from the CAL_GAP-th edge onward.
- R11: result_valid_o is high for exactly one cycle, and that cycle is the first cycle in which hold_o is low after a conversion.
- R12: Synchronous active-high reset clears all outputs and drops any calibration request seen before or during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-convert request, sampled on each rising edge |
| cal_n_i | input | 1 | Calibration request, active low |
| hold_o | output | 1 | Hold command to the track/hold |
| strobe_o | output | 3 | One-cycle flash strobe per pass, bit 0 is the first pass |
| dac_load_o | output | 2 | Reference DAC load after the first and the second pass |
| result_valid_o | output | 1 | One-cycle pulse when the hold command drops |
| cal_busy_o | output | 1 | High for the whole length of a calibration |

## Verification
The assertions assume that start_i and cal_n_i are synchronous to clk, that they are stable and free of X at every sampled edge once reset has been asserted, and that reset is applied from time zero. The bench drives every input one nanosecond after a rising edge. Each level is therefore held through the next edge, and the bench can tell exactly which edge sampled it. The stimulus places requests at the edges where blackout windows open and close, inside a running conversion, and during a running calibration. Both inputs are kept high or low for whole cycles only.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    localparam int NPASS = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CONV = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_CAL  = 2'd3
    } sq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    // hold cycle in which flash pass idx (0-based) is strobed
    function automatic int pass_slot(input int idx, input int s1, input int s2, input int s3);
        int t;
        t = s1;
        if (idx >= 1) t = t + 1 + s2;
        if (idx >= 2) t = t + 1 + s3;
        return t;
    endfunction

endpackage

// File: rtl/subrange_pass_decode.sv
module subrange_pass_decode
    import subrange_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SETTLE1 = 1,
    parameter int SETTLE2 = 2,
    parameter int SETTLE3 = 2
) (
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [NPASS-1:0] strobe_o,
    output logic [NPASS-2:0] load_o
);

    for (genvar i = 0; i < NPASS; i++) begin : g_pass
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(pass_slot(i, SETTLE1, SETTLE2, SETTLE3));
        assign strobe_o[i] = active_i && (cnt_i == SLOT);
        if (i < NPASS - 1) begin : g_load
            localparam logic [CNT_W-1:0] LOAD_SLOT =
                CNT_W'(pass_slot(i, SETTLE1, SETTLE2, SETTLE3) + 1);
            assign load_o[i] = active_i && (cnt_i == LOAD_SLOT);
        end
    end

endmodule

// File: rtl/subrange_cal_latch.sv
module subrange_cal_latch (
    input  logic clk,
    input  logic rst,
    input  logic cal_n_i,
    input  logic busy_i,
    input  logic take_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    always_comb begin
        if (take_i)
            pend_d = 1'b0;
        else
            pend_d = pend_q | (~cal_n_i & ~busy_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R6: a latched request survives until calibration takes it
    p_pend_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !take_i) |=> pend_q);

    // R8: nothing can be pending while calibration runs
    p_pend_clear_r8: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !pend_q);

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
    import subrange_pkg::*;
#(
    parameter int CAL_CLKS  = 150000,
    parameter int HOLD_CLKS = 13,
    parameter int CONV_GAP  = 7,
    parameter int CAL_GAP   = 17,
    parameter int SETTLE1   = 1,
    parameter int SETTLE2   = 2,
    parameter int SETTLE3   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cal_n_i,
    output logic             hold_o,
    output logic [NPASS-1:0] strobe_o,
    output logic [NPASS-2:0] dac_load_o,
    output logic             result_valid_o,
    output logic             cal_busy_o
);

    localparam int CNT_MAX = max3(CAL_CLKS, HOLD_CLKS, (CAL_GAP > CONV_GAP) ? CAL_GAP : CONV_GAP);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CLKS - 1);
    localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_CLKS - 1);
    localparam logic [CNT_W-1:0] CONV_LIM  = CNT_W'(CONV_GAP);
    localparam logic [CNT_W-1:0] CAL_LIM   = CNT_W'(CAL_GAP);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    typedef struct packed {
        sq_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             long_gap;
        logic             rv;
    } seq_t;

    seq_t s_d, s_q;
    logic pend;
    logic take;
    logic cal_req;
    logic [CNT_W-1:0] gap_lim;

    always_comb begin
        s_d     = s_q;
        s_d.rv  = 1'b0;
        take    = 1'b0;
        cal_req = pend | ~cal_n_i;
        gap_lim = s_q.long_gap ? CAL_LIM : CONV_LIM;

        case (s_q.state)
            SQ_IDLE: begin
                if (cal_req) begin
                    s_d.state = SQ_CAL;
                    s_d.cnt   = '0;
                    take      = 1'b1;
                end else if (start_i) begin
                    s_d.state = SQ_CONV;
                    s_d.cnt   = '0;
                end
            end
            SQ_CONV: begin
                if (s_q.cnt == HOLD_LAST) begin
                    s_d.state    = SQ_WAIT;
                    s_d.cnt      = CNT_ONE;
                    s_d.long_gap = 1'b0;
                    s_d.rv       = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_WAIT: begin
                if (cal_req) begin
                    s_d.state = SQ_CAL;
                    s_d.cnt   = '0;
                    take      = 1'b1;
                end else if (s_q.cnt == gap_lim) begin
                    s_d.state = start_i ? SQ_CONV : SQ_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SQ_CAL: begin
                if (s_q.cnt == CAL_LAST) begin
                    if (!cal_n_i) begin
                        s_d.cnt = '0;
                        take    = 1'b1;
                    end else begin
                        s_d.state    = SQ_WAIT;
                        s_d.cnt      = CNT_ONE;
                        s_d.long_gap = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            s_q <= '{state: SQ_IDLE, cnt: '0, long_gap: 1'b0, rv: 1'b0};
        else
            s_q <= s_d;
    end

    assign hold_o         = (s_q.state == SQ_CONV);
    assign cal_busy_o     = (s_q.state == SQ_CAL);
    assign result_valid_o = s_q.rv;

    subrange_cal_latch i_cal_latch (
        .clk     (clk),
        .rst     (rst),
        .cal_n_i (cal_n_i),
        .busy_i  (cal_busy_o),
        .take_i  (take),
        .pend_o  (pend)
    );

    subrange_pass_decode #(
        .CNT_W   (CNT_W),
        .SETTLE1 (SETTLE1),
        .SETTLE2 (SETTLE2),
        .SETTLE3 (SETTLE3)
    ) i_pass_decode (
        .active_i (hold_o),
        .cnt_i    (s_q.cnt),
        .strobe_o (strobe_o),
        .load_o   (dac_load_o)
    );

    // R7: hold and calibration never overlap
    p_hold_cal_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(hold_o && cal_busy_o));

    // R7: a calibration request outside conversion and calibration starts at once
    p_cal_now_r7: assert property (@(posedge clk) disable iff (rst)
        (!hold_o && !cal_busy_o && !cal_n_i) |=> cal_busy_o);

    // R8: no conversion directly follows a calibration cycle
    p_no_conv_after_cal_r8: assert property (@(posedge clk) disable iff (rst)
        cal_busy_o |=> !hold_o);

    // R11: result pulse coincides with the hold falling
    p_rv_on_fall_r11: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> $fell(hold_o));

    p_fall_gives_rv_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> result_valid_o);

    // R5: strobes and loads are exclusive and lie inside the hold window
    p_pass_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strobe_o, dac_load_o}));

    p_pass_in_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (|{strobe_o, dac_load_o}) |-> hold_o);

endmodule

// File: tb/test_subrange_seq.sv
module test_subrange_seq;

    localparam int CAL = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       cal_n_i = 1'b1;
    logic       hold_o;
    logic [2:0] strobe_o;
    logic [1:0] dac_load_o;
    logic       result_valid_o;
    logic       cal_busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    subrange_seq #(.CAL_CLKS(CAL)) i_subrange_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .cal_n_i        (cal_n_i),
        .hold_o         (hold_o),
        .strobe_o       (strobe_o),
        .dac_load_o     (dac_load_o),
        .result_valid_o (result_valid_o),
        .cal_busy_o     (cal_busy_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        start_i = 1'b0;
        cal_n_i = 1'b1;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b1; cal_n_i = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk("R12", "outputs in reset", {hold_o, strobe_o, dac_load_o, result_valid_o, cal_busy_o}, 0);
        rst = 1'b0; start_i = 1'b0; cal_n_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R12", "no calibration left from reset", cal_busy_o, 0);
            chk("R12", "no conversion after reset", hold_o, 0);
        end
    endtask

    task automatic t_conv();
        int es, el;
        start_i = 1'b1;
        step();
        chk("R1", "hold after accepted start", hold_o, 1);
        start_i = 1'b0;
        for (int k = 0; k <= 14; k++) begin
            if (k > 0) step();
            es = (k == 1) ? 1 : (k == 4) ? 2 : (k == 7) ? 4 : 0;
            el = (k == 2) ? 1 : (k == 5) ? 2 : 0;
            chk("R2", $sformatf("hold at cycle %0d", k), hold_o, (k <= 12) ? 1 : 0);
            chk("R5", $sformatf("strobe at cycle %0d", k), strobe_o, es);
            chk("R5", $sformatf("dac load at cycle %0d", k), dac_load_o, el);
            chk("R11", $sformatf("result pulse at cycle %0d", k), result_valid_o, (k == 13) ? 1 : 0);
        end
        idle(20);
    endtask

    task automatic t_repeat();
        int rises[4];
        int n = 0;
        bit prev = 1'b0;
        start_i = 1'b1;
        for (int c = 0; c < 120 && n < 4; c++) begin
            step();
            if (hold_o && !prev) begin
                rises[n] = c;
                n++;
            end
            prev = hold_o;
        end
        chk("R3", "conversions seen", n, 4);
        for (int i = 1; i < 4; i++)
            chk("R3", "conversion period", rises[i] - rises[i-1], 20);
        idle(40);
    endtask

    task automatic t_blackout();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 1; k <= 13; k++) step();
        start_i = 1'b1;
        for (int k = 14; k <= 19; k++) begin
            step();
            chk("R4", $sformatf("start ignored, cycle %0d", k), hold_o, 0);
        end
        start_i = 1'b0;
        for (int k = 20; k <= 25; k++) begin
            step();
            chk("R4", $sformatf("no late conversion, cycle %0d", k), hold_o, 0);
        end
        idle(10);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 1; k <= 21; k++) step();
        start_i = 1'b1;
        step();
        chk("R4", "start sampled after window", hold_o, 1);
        start_i = 1'b0;
        idle(40);
    endtask

    task automatic t_cal_pending();
        int cnt = 1;
        int guard = 0;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        for (int k = 1; k <= 3; k++) step();
        cal_n_i = 1'b0;
        step();
        cal_n_i = 1'b1;
        for (int k = 5; k <= 12; k++) begin
            step();
            chk("R6", $sformatf("conversion kept, cycle %0d", k), {hold_o, cal_busy_o}, 2);
        end
        step();
        chk("R6", "no calibration as hold falls", cal_busy_o, 0);
        step();
        chk("R6", "pending calibration starts", cal_busy_o, 1);
        while (guard < 4 * CAL) begin
            step();
            guard++;
            if (guard == 10) cal_n_i = 1'b0;
            if (guard == 11) cal_n_i = 1'b1;
            if (!cal_busy_o) break;
            cnt++;
        end
        chk("R8", "calibration length", cnt, CAL);
        start_i = 1'b1;
        for (int j = 1; j <= 17; j++) begin
            step();
            chk("R10", $sformatf("recovery edge %0d", j), hold_o, (j == 17) ? 1 : 0);
        end
        start_i = 1'b0;
        for (int j = 0; j < 40; j++) begin
            step();
            if (j == 39) chk("R8", "pulse during busy left nothing", cal_busy_o, 0);
        end
        idle(10);
    endtask

    task automatic t_cal_idle();
        int guard = 0;
        cal_n_i = 1'b0;
        start_i = 1'b1;
        step();
        chk("R7", "calibration wins over start", {hold_o, cal_busy_o}, 1);
        cal_n_i = 1'b1;
        start_i = 1'b0;
        while (cal_busy_o && guard < 4 * CAL) begin
            step();
            guard++;
        end
        chk("R7", "calibration ended", cal_busy_o, 0);
        idle(40);
    endtask

    task automatic t_cal_back();
        int cnt = 1;
        cal_n_i = 1'b0;
        step();
        chk("R9", "calibration starts", cal_busy_o, 1);
        for (int j = 1; j < 5 * CAL; j++) begin
            if (j == CAL + 5) cal_n_i = 1'b1;
            step();
            if (!cal_busy_o) break;
            cnt++;
        end
        chk("R9", "back-to-back busy length", cnt, 2 * CAL);
        idle(40);
    endtask

    initial begin
        t_reset();
        t_conv();
        t_repeat();
        t_blackout();
        t_cal_pending();
        t_cal_idle();
        t_cal_back();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule